// File: doc/BRIEF.md
# Tagged Integer Register File

This block is a 128-entry integer register file. Each entry stores a 64-bit value and a one-bit poison tag. When the tag is set, the value is invalid, for example because a speculative load was deferred. The file has two combinational read ports and one write port. A write is forwarded to a read port that addresses the same entry in the same cycle, and the forwarded result carries both value and tag.

Entry 0 is hardwired: it always reads as zero with a clear tag. An attempt to write it is not silently dropped. Instead it raises a fault.

A small tag unit sits beside the read ports and serves the ALU:
- For an arithmetic operation, it produces the result tag by OR-ing the two operand tags.
- For a non-arithmetic use of a tagged operand, such as a store, it raises a fault.

Faults are reported as a registered one-cycle pulse together with a cause code. Each read port also reports whether its index lies in the static range or in the stacked range.

Top module: `tagged_regfile`

## Requirements
- R1: Every entry 1..127 stores a 64-bit value and a tag bit written through the write port. The stored pair is readable on both read ports from the cycle after the write.
- R2: A read of entry 0 returns value zero with the tag clear, whatever the write port is doing.
- R3: A write with `wr_en`=1 to index 0 raises `fault`=1 with `fault_cause`=2'b01 in the following cycle, and it changes no stored state.
- R4: Each read port's `stacked` output is 0 for indices 0..31 and 1 for indices 32..127.
- R5: `res_tag` equals `rd_a_tag | rd_b_tag` while `op_valid`=1 and `op_arith`=1. Otherwise `res_tag` is 0.
- R6: With `op_valid`=1 and `op_arith`=0, a set tag on either read port raises `fault`=1 with `fault_cause`=2'b10 in the following cycle. If a write to entry 0 happens in the same cycle, cause 2'b01 takes precedence.
- R7: When a write to a nonzero index and a read of that index happen in the same cycle, the read port returns the written value and tag.
- R8: `fault` is high for exactly one cycle per offending cycle. `fault_cause` is 2'b00 whenever `fault` is 0.
- R9: Synchronous active-high reset clears every entry to value zero with the tag clear. It also clears `fault`.
- R10: A write that coincides with a fault raised in the same cycle is not committed, and the entry keeps its previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 7 | Read port A index |
| rd_a_data | output | 64 | Read port A value |
| rd_a_tag | output | 1 | Read port A poison tag |
| rd_a_stacked | output | 1 | Index A lies in the stacked range |
| rd_b_idx | input | 7 | Read port B index |
| rd_b_data | output | 64 | Read port B value |
| rd_b_tag | output | 1 | Read port B poison tag |
| rd_b_stacked | output | 1 | Index B lies in the stacked range |
| wr_en | input | 1 | Write request |
| wr_idx | input | 7 | Write index |
| wr_data | input | 64 | Write value |
| wr_tag | input | 1 | Write poison tag |
| op_valid | input | 1 | An operation consumes the read ports this cycle |
| op_arith | input | 1 | 1 = arithmetic operation, 0 = non-arithmetic use |
| res_tag | output | 1 | Combined tag for an arithmetic result |
| fault | output | 1 | Registered one-cycle fault pulse |
| fault_cause | output | 2 | 01 = zero-entry write, 10 = tagged operand in a non-arithmetic use |

## Verification
The hardest situation to reach is a legal write that is suppressed because a fault occurs in the same cycle. It needs a tagged value already stored in one entry, a non-arithmetic operation that reads that entry, and a concurrent write to a different entry, all at once. The stimulus first fills every entry with a computed pattern whose tag follows an arithmetic rule. It then picks a known tagged entry as the operand while writing elsewhere, and afterwards reads the written entry back to confirm it is unchanged. A second run adds a zero-entry write to the same cycle to exercise cause precedence.

// File: rtl/tagged_regfile_pkg.sv
package tagged_regfile_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_ZERO_WR = 2'b01,
    CAUSE_TAG_USE = 2'b10
  } fault_cause_e;
endpackage

// File: rtl/trf_storage.sv
module trf_storage #(
  parameter int NREG = 128,
  parameter int DW   = 64,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic                    wtag,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata,
  output logic [NRD-1:0]          rtag
);
  logic [DW-1:0] mem_val [NREG];
  logic          mem_tag [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        mem_val[i] <= '0;
        mem_tag[i] <= 1'b0;
      end
    end else if (we) begin
      mem_val[waddr] <= wdata;
      mem_tag[waddr] <= wtag;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem_val[raddr[p]];
    assign rtag[p]  = mem_tag[raddr[p]];
  end

  // R10 / R3: the top never commits a write to the hardwired entry
  always_comb begin
    if (!rst && we) assert_commit_nonzero_R3: assert (waddr != '0);
  end
endmodule

// File: rtl/trf_read_port.sv
module trf_read_port #(
  parameter int NREG       = 128,
  parameter int DW         = 64,
  parameter int STATIC_CNT = 32,
  localparam int AW        = $clog2(NREG)
) (
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] store_data,
  input  logic          store_tag,
  input  logic          fwd_en,
  input  logic [AW-1:0] fwd_idx,
  input  logic [DW-1:0] fwd_data,
  input  logic          fwd_tag,
  output logic [DW-1:0] data,
  output logic          tag,
  output logic          stacked
);
  logic hit;
  assign hit = fwd_en && (fwd_idx == idx);

  always_comb begin
    if (idx == '0) begin
      data = '0;
      tag  = 1'b0;
    end else if (hit) begin
      data = fwd_data;
      tag  = fwd_tag;
    end else begin
      data = store_data;
      tag  = store_tag;
    end
  end

  assign stacked = (idx >= AW'(STATIC_CNT));
endmodule

// File: rtl/trf_tag_unit.sv
module trf_tag_unit
  import tagged_regfile_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       op_valid,
  input  logic       op_arith,
  input  logic       tag_a,
  input  logic       tag_b,
  input  logic       zero_wr,
  output logic       res_tag,
  output logic       fault_now,
  output logic       fault,
  output logic [1:0] fault_cause
);
  logic         tag_use;
  fault_cause_e cause_d;
  fault_cause_e cause_q;

  assign res_tag = op_valid && op_arith && (tag_a || tag_b);
  assign tag_use = op_valid && !op_arith && (tag_a || tag_b);

  always_comb begin
    if (zero_wr)      cause_d = CAUSE_ZERO_WR;
    else if (tag_use) cause_d = CAUSE_TAG_USE;
    else              cause_d = CAUSE_NONE;
  end
  assign fault_now = (cause_d != CAUSE_NONE);

  always_ff @(posedge clk) begin
    if (rst) cause_q <= CAUSE_NONE;
    else     cause_q <= cause_d;
  end

  assign fault       = (cause_q != CAUSE_NONE);
  assign fault_cause = cause_q;

  assert_reset_clears_fault_R9: assert property (@(posedge clk)
    $past(rst) |-> !fault);
  assert_fault_follows_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!zero_wr && !tag_use) |-> !fault);
endmodule

// File: rtl/tagged_regfile.sv
module tagged_regfile #(
  parameter int NREG       = 128,
  parameter int DW         = 64,
  parameter int STATIC_CNT = 32,
  localparam int AW        = $clog2(NREG),
  localparam int NRD       = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  output logic          rd_a_tag,
  output logic          rd_a_stacked,
  input  logic [AW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  output logic          rd_b_tag,
  output logic          rd_b_stacked,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_tag,
  input  logic          op_valid,
  input  logic          op_arith,
  output logic          res_tag,
  output logic          fault,
  output logic [1:0]    fault_cause
);
  logic                   zero_wr, fwd_en, commit, fault_now;
  logic [NRD-1:0][AW-1:0] ridx;
  logic [NRD-1:0][DW-1:0] sdata, pdata;
  logic [NRD-1:0]         stag, ptag, pstk;

  assign zero_wr = wr_en && (wr_idx == '0);
  assign fwd_en  = wr_en && (wr_idx != '0);
  assign commit  = fwd_en && !fault_now;

  assign ridx[0] = rd_a_idx;
  assign ridx[1] = rd_b_idx;

  trf_storage #(.NREG(NREG), .DW(DW), .NRD(NRD)) u_store (
    .clk(clk), .rst(rst), .we(commit), .waddr(wr_idx), .wdata(wr_data),
    .wtag(wr_tag), .raddr(ridx), .rdata(sdata), .rtag(stag)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_port
    trf_read_port #(.NREG(NREG), .DW(DW), .STATIC_CNT(STATIC_CNT)) u_rp (
      .idx(ridx[p]), .store_data(sdata[p]), .store_tag(stag[p]),
      .fwd_en(fwd_en), .fwd_idx(wr_idx), .fwd_data(wr_data), .fwd_tag(wr_tag),
      .data(pdata[p]), .tag(ptag[p]), .stacked(pstk[p])
    );
  end

  assign rd_a_data = pdata[0];
  assign rd_a_tag = ptag[0];
  assign rd_a_stacked = pstk[0];
  assign rd_b_data = pdata[1];
  assign rd_b_tag = ptag[1];
  assign rd_b_stacked = pstk[1];

  trf_tag_unit u_tag (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_arith(op_arith),
    .tag_a(ptag[0]), .tag_b(ptag[1]), .zero_wr(zero_wr),
    .res_tag(res_tag), .fault_now(fault_now), .fault(fault),
    .fault_cause(fault_cause)
  );

  assert_zero_write_faults_R3: assert property (@(posedge clk) disable iff (rst)
    zero_wr |=> (fault && fault_cause == 2'b01));
  assert_tag_use_faults_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_arith && (rd_a_tag || rd_b_tag) && !zero_wr)
      |=> (fault && fault_cause == 2'b10));
  assert_arith_tag_merge_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_arith) |-> (res_tag == (rd_a_tag || rd_b_tag)));
  assert_zero_reads_clean_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == '0) |-> (rd_a_data == '0 && !rd_a_tag));
endmodule

// File: tb/tagged_regfile_tb.sv
module tagged_regfile_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [6:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [63:0] rd_a_data, rd_b_data, wr_data;
  logic        rd_a_tag, rd_b_tag, rd_a_stacked, rd_b_stacked;
  logic        wr_en, wr_tag, op_valid, op_arith, res_tag, fault;
  logic [1:0]  fault_cause;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  tagged_regfile u_dut (.*);

  function automatic logic [63:0] pat(int i, int k);
    return {8'(k), 24'(i * 7 + 3), 32'(i) ^ 32'hDEAD_BEEF} ^ 64'(k * 13);
  endfunction
  function automatic logic ptg(int i, int k);
    return ((i + k) % 3) == 0;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_idx = 0; wr_data = 0; wr_tag = 0;
    op_valid = 0; op_arith = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check_all_zero(string req);
    for (int i = 0; i < 128; i++) begin
      rd_a_idx = 7'(i); rd_b_idx = 7'(127 - i); #1;
      chk(req, {rd_a_tag, rd_a_data[62:0]} | 64'(rd_a_data[63]), 0);
      chk(req, {63'(0), rd_b_tag}, 0);
      chk("R4", {63'(0), rd_a_stacked}, {63'(0), i >= 32});
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(); rst = 1; rd_a_idx = 0; rd_b_idx = 0;
    @(negedge clk); tick();
    // R9: reset state
    chk("R9", {63'(0), fault}, 0);
    rst = 0;
    check_all_zero("R9");

    // R1: fill and read back on both ports
    for (int i = 1; i < 128; i++) begin
      wr_en = 1; wr_idx = 7'(i); wr_data = pat(i, 1); wr_tag = ptg(i, 1);
      tick();
    end
    idle();
    for (int i = 0; i < 128; i++) begin
      rd_a_idx = 7'(i); rd_b_idx = 7'(127 - i); #1;
      chk("R1", rd_a_data, i == 0 ? 64'd0 : pat(i, 1));
      chk("R1", {63'(0), rd_a_tag}, {63'(0), i == 0 ? 1'b0 : ptg(i, 1)});
      chk("R1", rd_b_data, i == 127 ? 64'd0 : pat(127 - i, 1));
      chk("R1", {63'(0), rd_b_tag}, {63'(0), i == 127 ? 1'b0 : ptg(127 - i, 1)});
      chk("R4", {63'(0), rd_b_stacked}, {63'(0), (127 - i) >= 32});
    end

    // R7: same-cycle forwarding
    wr_en = 1; wr_idx = 40; wr_data = pat(40, 2); wr_tag = 1;
    rd_a_idx = 40; rd_b_idx = 41; #1;
    chk("R7", rd_a_data, pat(40, 2));
    chk("R7", {63'(0), rd_a_tag}, 1);
    chk("R7", rd_b_data, pat(41, 1));
    tick(); idle(); #1;
    chk("R1", rd_a_data, pat(40, 2));

    // R2/R3: zero-entry write
    wr_en = 1; wr_idx = 0; wr_data = '1; wr_tag = 1; rd_a_idx = 0; #1;
    chk("R2", rd_a_data, 0);
    chk("R2", {63'(0), rd_a_tag}, 0);
    tick(); idle();
    chk("R3", {62'(0), fault, fault_cause[0]} | {62'(0), fault_cause[1], 1'b0}, 64'b11);
    chk("R3", {62'(0), fault_cause}, 1);
    #1; chk("R3", rd_a_data, 0);
    tick();
    chk("R8", {63'(0), fault}, 0);
    chk("R8", {62'(0), fault_cause}, 0);

    // R5/R6: tag helper sweep (entry 2 tagged, entry 3 clean under k=1)
    for (int c = 0; c < 16; c++) begin
      logic ta, tb, v, ar, ef;
      ta = c[0]; tb = c[1]; v = c[2]; ar = c[3];
      rd_a_idx = ta ? 7'd2 : 7'd3; rd_b_idx = tb ? 7'd2 : 7'd3;
      op_valid = v; op_arith = ar; #1;
      chk("R5", {63'(0), res_tag}, {63'(0), v & ar & (ta | tb)});
      ef = v & ~ar & (ta | tb);
      tick(); idle();
      chk("R6", {63'(0), fault}, {63'(0), ef});
      chk("R6", {62'(0), fault_cause}, ef ? 64'd2 : 64'd0);
      tick();
      chk("R8", {63'(0), fault}, 0);
    end

    // R10: write suppressed by tagged-operand fault
    wr_en = 1; wr_idx = 10; wr_data = pat(10, 5); wr_tag = 0;
    rd_a_idx = 2; rd_b_idx = 3; op_valid = 1; op_arith = 0;
    tick(); idle();
    chk("R10", {62'(0), fault_cause}, 2);
    rd_a_idx = 10; #1;
    chk("R10", rd_a_data, pat(10, 1));
    chk("R10", {63'(0), rd_a_tag}, {63'(0), ptg(10, 1)});
    tick();

    // R6 precedence: zero write and tagged use together
    wr_en = 1; wr_idx = 0; wr_data = 5; rd_a_idx = 2; op_valid = 1; op_arith = 0;
    tick(); idle();
    chk("R6", {62'(0), fault_cause}, 1);
    tick();

    // R9: reset again clears stored state
    rst = 1; tick(); rst = 0;
    chk("R9", {63'(0), fault}, 0);
    check_all_zero("R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule